// File: doc/BRIEF.md
# Local descriptor table register loader

This block takes a 16-bit selector and, after a set of privilege, mode and table checks, fetches the system descriptor it names from the global descriptor table and loads the local descriptor table register. That register has a visible selector and a hidden base, limit and valid bit. A request is a one-cycle `start` pulse. The selector, the global table base and limit, the mode flags and the current privilege level are all sampled on that pulse.

Checks that need no memory access are settled on the `start` edge. Those outcomes are an invalid-opcode fault, a privilege fault, a null selector, a table-indicator fault and a table-limit fault. Every other request reads the descriptor through a simple request/valid port, one 8-byte chunk at a time. In 64-bit mode there are two chunks and a 64-bit base; in other modes there is one chunk and a 32-bit base. The result is reported by a one-cycle `done` pulse with an exception code and an error selector. Both stay valid until the next request.

Top module: `ldt_load_check`

## Requirements
- R1: After reset, `ldt_sel`, `ldt_base`, `ldt_limit`, `ldt_valid`, `exc_code`, `err_sel`, `busy`, `done` and `rd_req` are all zero.
- R2: When `prot_mode` is 0 at `start`, `done` rises on the next cycle with `exc_code` = 1 (invalid opcode) and `err_sel` = 0, and no read is issued.
- R3: When `prot_mode` is 1 and `cpl` is not 0 at `start`, `done` rises on the next cycle with `exc_code` = 2 (general protection) and `err_sel` = 0, and no read is issued.
- R4: A null selector is one with `sel_in[15:2]` = 0, so the RPL bits are ignored. With privilege level 0 it completes on the next cycle with `exc_code` = 0. `ldt_sel` takes the selector, `ldt_valid` is cleared, and no read is issued.
- R5: A non-null selector with the table-indicator bit `sel_in[2]` set faults with `exc_code` = 2 and `err_sel` = `{sel_in[15:2],2'b00}`, with no read.
- R6: The descriptor end is index×8 + 7, or index×8 + 15 in 64-bit mode, where index = `sel_in[15:3]`. The end is computed with 17 bits. If it is greater than `gdt_limit`, the request faults with `exc_code` = 2, the selector in `err_sel` and no read. An end equal to the limit passes.
- R7: The first read address is `gdt_base` + index×8. In 64-bit mode a second read follows at that address + 8. The number of reads is 0, 1 or 2 as described above.
- R8: The first chunk's bits 44:40 (system flag and type) must equal 5'b00010. Otherwise the request faults with `exc_code` = 2 and the selector in `err_sel`.
- R9: If the type is correct and the present bit (bit 47 of the first chunk) is 0, the request faults with `exc_code` = 3 (not present) and the selector in `err_sel`.
- R10: In 64-bit mode, bits 63:32 of the second chunk are extended attribute bits and must all be zero. The assembled base must also be canonical: bits 63:47 all equal. Either failure gives `exc_code` = 2 with the selector in `err_sel`.
- R11: A successful load outside 64-bit mode sets `ldt_base` = {chunk[63:56], chunk[39:16]}, zero-extended, and `ldt_valid` = 1. The 20-bit limit is {chunk[51:48], chunk[15:0]}. `ldt_limit` is that limit, or {limit, 12'hFFF} when bit 55 is set.
- R12: A successful 64-bit-mode load sets `ldt_base` = {chunk1[31:0], chunk0[63:56], chunk0[39:16]}. The limit and valid bit are set as in R11.
- R13: `done` is a one-cycle pulse. `exc_code` and `err_sel` hold until the next request. A faulting request leaves `ldt_sel`, `ldt_base`, `ldt_limit` and `ldt_valid` unchanged. `start` is ignored while `busy` is high.
- R14: Fault priority, highest first, is: invalid opcode, privilege, null selector (success), table indicator, table limit, type, extended attributes, present, canonical base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse; samples all request inputs |
| sel_in | input | 16 | Selector to load |
| prot_mode | input | 1 | Protected mode active |
| long_mode | input | 1 | 64-bit mode active |
| cpl | input | 2 | Current privilege level |
| gdt_base | input | 64 | Global table base address |
| gdt_limit | input | 16 | Global table limit |
| rd_req | output | 1 | Descriptor chunk read request |
| rd_addr | output | 64 | Address of the requested chunk |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 64 | Read data chunk |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| exc_code | output | 2 | 0 none, 1 invalid opcode, 2 general protection, 3 not present |
| err_sel | output | 16 | Error selector of the last fault |
| ldt_sel | output | 16 | Visible selector |
| ldt_base | output | 64 | Hidden base |
| ldt_limit | output | 32 | Hidden byte limit |
| ldt_valid | output | 1 | Register holds a usable descriptor |

## Verification
A corrupted request state shows up at the ports within a few cycles. It appears as a read at the wrong address, as the wrong number of reads, or as a `done` pulse that never comes or comes twice. A wrongly latched selector or mode shows up at the next `done` in `err_sel`, in the read count or in the base width. A bad field extraction or fault ordering shows up at that same pulse in `exc_code` or the loaded base and limit. A fault that disturbs the register is exposed by comparing the hidden state against the last successful load after every request.

// File: rtl/ldt_load_check.sv
module ldt_load_check #(
  parameter int VA_BITS = 48
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] sel_in,
  input  logic        prot_mode,
  input  logic        long_mode,
  input  logic [1:0]  cpl,
  input  logic [63:0] gdt_base,
  input  logic [15:0] gdt_limit,
  output logic        rd_req,
  output logic [63:0] rd_addr,
  input  logic        rd_valid,
  input  logic [63:0] rd_data,
  output logic        busy,
  output logic        done,
  output logic [1:0]  exc_code,
  output logic [15:0] err_sel,
  output logic [15:0] ldt_sel,
  output logic [63:0] ldt_base,
  output logic [31:0] ldt_limit,
  output logic        ldt_valid
);
  localparam logic [1:0] EX_NONE = 2'd0;
  localparam logic [1:0] EX_UD   = 2'd1;
  localparam logic [1:0] EX_GP   = 2'd2;
  localparam logic [1:0] EX_NP   = 2'd3;
  localparam int CANON_LSB = VA_BITS - 1;

  typedef enum logic [1:0] {S_IDLE, S_RD_LO, S_RD_HI, S_EVAL} state_t;
  state_t state;

  logic [15:0] sel_q;
  logic        long_q;
  logic [63:0] addr_q;
  logic [63:0] lo_q;
  logic [63:0] hi_q;

  logic [16:0] end_off;
  logic        sel_null;
  logic        past_limit;
  assign end_off    = {1'b0, sel_in[15:3], 3'b000} + (long_mode ? 17'd15 : 17'd7);
  assign past_limit = end_off > {1'b0, gdt_limit};
  assign sel_null   = sel_in[15:2] == 14'd0;

  assign busy    = state != S_IDLE;
  assign rd_req  = state == S_RD_LO || state == S_RD_HI;
  assign rd_addr = addr_q + (state == S_RD_HI ? 64'd8 : 64'd0);

  logic [63:0] new_base;
  logic [19:0] raw_lim;
  logic [31:0] new_lim;
  logic [63:CANON_LSB] canon_bits;
  logic type_bad, ext_bad, not_present, canon_bad;
  logic unused_bits;

  assign new_base    = {long_q ? hi_q[31:0] : 32'd0, lo_q[63:56], lo_q[39:16]};
  assign raw_lim     = {lo_q[51:48], lo_q[15:0]};
  assign new_lim     = lo_q[55] ? {raw_lim, 12'hFFF} : {12'd0, raw_lim};
  assign canon_bits  = new_base[63:CANON_LSB];
  assign type_bad    = lo_q[44:40] != 5'b00010;
  assign ext_bad     = long_q && (hi_q[63:32] != 32'd0);
  assign not_present = !lo_q[47];
  assign canon_bad   = long_q && !((&canon_bits) || !(|canon_bits));
  assign unused_bits = ^{lo_q[54:52], lo_q[46:45]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      sel_q     <= '0;
      long_q    <= 1'b0;
      addr_q    <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      done      <= 1'b0;
      exc_code  <= EX_NONE;
      err_sel   <= '0;
      ldt_sel   <= '0;
      ldt_base  <= '0;
      ldt_limit <= '0;
      ldt_valid <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          sel_q  <= sel_in;
          long_q <= long_mode;
          hi_q   <= '0;
          addr_q <= gdt_base + {48'd0, sel_in[15:3], 3'b000};
          if (!prot_mode) begin
            done <= 1'b1; exc_code <= EX_UD; err_sel <= '0;
          end else if (cpl != 2'd0) begin
            done <= 1'b1; exc_code <= EX_GP; err_sel <= '0;
          end else if (sel_null) begin
            done      <= 1'b1;
            exc_code  <= EX_NONE;
            err_sel   <= '0;
            ldt_sel   <= sel_in;
            ldt_valid <= 1'b0;
          end else if (sel_in[2] || past_limit) begin
            done <= 1'b1; exc_code <= EX_GP; err_sel <= {sel_in[15:2], 2'b00};
          end else begin
            state <= S_RD_LO;
          end
        end
        S_RD_LO: if (rd_valid) begin
          lo_q  <= rd_data;
          state <= long_q ? S_RD_HI : S_EVAL;
        end
        S_RD_HI: if (rd_valid) begin
          hi_q  <= rd_data;
          state <= S_EVAL;
        end
        default: begin
          state <= S_IDLE;
          done  <= 1'b1;
          if (type_bad || ext_bad) begin
            exc_code <= EX_GP; err_sel <= {sel_q[15:2], 2'b00};
          end else if (not_present) begin
            exc_code <= EX_NP; err_sel <= {sel_q[15:2], 2'b00};
          end else if (canon_bad) begin
            exc_code <= EX_GP; err_sel <= {sel_q[15:2], 2'b00};
          end else begin
            exc_code  <= EX_NONE;
            err_sel   <= '0;
            ldt_sel   <= sel_q;
            ldt_base  <= new_base;
            ldt_limit <= new_lim;
            ldt_valid <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ldt_load_check_sva.sv
module ldt_load_check_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [15:0] sel_in,
  input logic        prot_mode,
  input logic [1:0]  cpl,
  input logic        rd_req,
  input logic        busy,
  input logic        done,
  input logic [1:0]  exc_code,
  input logic [15:0] err_sel,
  input logic [15:0] ldt_sel,
  input logic [63:0] ldt_base,
  input logic        ldt_valid
);
  a_r2_undefined_op: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !prot_mode |=> done && exc_code == 2'd1 && !rd_req);

  a_r3_privilege: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && prot_mode && cpl != 2'd0 |=> done && exc_code == 2'd2 && err_sel == 16'd0 && !rd_req);

  a_r4_null_selector: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && prot_mode && cpl == 2'd0 && sel_in[15:2] == 14'd0
      |=> done && exc_code == 2'd0 && !ldt_valid && !rd_req);

  a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r13_fault_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    done && exc_code != 2'd0 |-> $stable(ldt_valid) && $stable(ldt_base) && $stable(ldt_sel));

  a_r11_valid_on_success: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ldt_valid) |-> done && exc_code == 2'd0);
endmodule

bind ldt_load_check ldt_load_check_sva u_sva (.*);

// File: tb/test_ldt_load_check.sv
`timescale 1ns/1ps
module test_ldt_load_check;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start, prot_mode, long_mode, rd_valid, rd_req, busy, done, ldt_valid;
  logic [1:0]  cpl, exc_code;
  logic [15:0] sel_in, gdt_limit, err_sel, ldt_sel;
  logic [63:0] gdt_base, rd_addr, rd_data, ldt_base;
  logic [31:0] ldt_limit;

  ldt_load_check i_ldt_load_check (.*);

  localparam logic [63:0] GBASE = 64'h0000_0000_0010_0000;
  localparam logic [63:0] D_OK  = 64'h1200_8234_5678_0FFF;
  localparam logic [63:0] D_NP  = 64'h1200_0234_5678_0FFF;
  localparam logic [63:0] H_OK  = 64'h0000_0000_FFFF_8000;
  localparam logic [63:0] H_EXT = 64'h0000_0100_0000_0000;
  localparam logic [63:0] H_NC  = 64'h0000_0000_0000_8000;

  typedef struct packed {
    bit        prot; bit lng; bit [1:0] cpl; bit [15:0] sel; bit [15:0] glim;
    bit [63:0] lo; bit [63:0] hi; bit [1:0] exc; bit [15:0] err; bit [1:0] nrd;
    bit        ld; bit [63:0] base; bit [31:0] lim; bit [7:0] rq;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VT [NV] = '{
    '{1'b0,1'b0,2'd3,16'h0028,16'hFFFF,D_OK,64'd0,2'd1,16'h0000,2'd0,1'b0,64'd0,32'd0,8'd2},   // R2, R14 (UD over CPL)
    '{1'b1,1'b0,2'd1,16'h0000,16'hFFFF,D_OK,64'd0,2'd2,16'h0000,2'd0,1'b0,64'd0,32'd0,8'd3},   // R3, R14 (CPL over null)
    '{1'b1,1'b0,2'd0,16'h002B,16'h002F,D_OK,64'd0,2'd0,16'h0000,2'd1,1'b1,64'h0000_0000_1234_5678,32'h0000_0FFF,8'd11}, // R11, R6 edge
    '{1'b1,1'b0,2'd0,16'h0003,16'hFFFF,D_OK,64'd0,2'd0,16'h0000,2'd0,1'b0,64'd0,32'd0,8'd4},   // R4
    '{1'b1,1'b0,2'd0,16'h002C,16'hFFFF,D_OK,64'd0,2'd2,16'h002C,2'd0,1'b0,64'd0,32'd0,8'd5},   // R5
    '{1'b1,1'b0,2'd0,16'h0028,16'h002E,D_OK,64'd0,2'd2,16'h0028,2'd0,1'b0,64'd0,32'd0,8'd6},   // R6
    '{1'b1,1'b1,2'd0,16'h0028,16'h0036,D_OK,H_OK,2'd2,16'h0028,2'd0,1'b0,64'd0,32'd0,8'd6},    // R6 64-bit
    '{1'b1,1'b1,2'd0,16'h002A,16'h0037,D_OK,H_OK,2'd0,16'h0000,2'd2,1'b1,64'hFFFF_8000_1234_5678,32'h0000_0FFF,8'd12}, // R12, R7
    '{1'b1,1'b0,2'd0,16'h0028,16'hFFFF,64'h1200_8934_5678_0FFF,64'd0,2'd2,16'h0028,2'd1,1'b0,64'd0,32'd0,8'd8}, // R8
    '{1'b1,1'b0,2'd0,16'h0029,16'hFFFF,64'h1200_9234_5678_0FFF,64'd0,2'd2,16'h0028,2'd1,1'b0,64'd0,32'd0,8'd8}, // R8 data type
    '{1'b1,1'b0,2'd0,16'h0028,16'hFFFF,D_NP,64'd0,2'd3,16'h0028,2'd1,1'b0,64'd0,32'd0,8'd9},   // R9
    '{1'b1,1'b0,2'd0,16'h0028,16'hFFFF,64'h1200_0934_5678_0FFF,64'd0,2'd2,16'h0028,2'd1,1'b0,64'd0,32'd0,8'd14}, // R14 type over present
    '{1'b1,1'b1,2'd0,16'h0028,16'hFFFF,D_OK,H_EXT,2'd2,16'h0028,2'd2,1'b0,64'd0,32'd0,8'd10},  // R10 ext
    '{1'b1,1'b1,2'd0,16'h0028,16'hFFFF,D_OK,H_NC,2'd2,16'h0028,2'd2,1'b0,64'd0,32'd0,8'd10},   // R10 canonical
    '{1'b1,1'b1,2'd0,16'h0028,16'hFFFF,D_NP,H_NC,2'd3,16'h0028,2'd2,1'b0,64'd0,32'd0,8'd14},   // R14 present over canonical
    '{1'b1,1'b1,2'd0,16'h0028,16'hFFFF,D_NP,H_EXT,2'd2,16'h0028,2'd2,1'b0,64'd0,32'd0,8'd14},  // R14 ext over present
    '{1'b1,1'b0,2'd0,16'h0028,16'hFFFF,64'hAB82_82CD_EF01_0001,64'd0,2'd0,16'h0000,2'd1,1'b1,64'h0000_0000_ABCD_EF01,32'h2000_1FFF,8'd11}, // R11 granular
    '{1'b1,1'b0,2'd0,16'hFFF8,16'hFFFF,D_OK,64'd0,2'd0,16'h0000,2'd1,1'b1,64'h0000_0000_1234_5678,32'h0000_0FFF,8'd7}, // R7, R6 top index
    '{1'b1,1'b1,2'd0,16'hFFF8,16'hFFFF,D_OK,H_OK,2'd2,16'hFFF8,2'd0,1'b0,64'd0,32'd0,8'd6}     // R6 17-bit end
  };

  int n_chk = 0, n_fail = 0, reads = 0;
  logic [63:0] cur_lo, cur_hi, exp_addr0;
  logic [15:0] m_sel; logic [63:0] m_base; logic [31:0] m_lim; logic m_valid;

  task automatic chk(input int rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rd_req && !rd_valid) begin
      if (reads == 0) begin
        chk(7, "first read address", rd_addr, exp_addr0);
        rd_data = cur_lo;
      end else begin
        chk(7, "second read address", rd_addr, exp_addr0 + 64'd8);
        rd_data = cur_hi;
      end
      reads++;
      rd_valid = 1'b1;
    end else begin
      rd_valid = 1'b0;
    end
  end

  task automatic run_vec(input vec_t v);
    int n;
    @(negedge clk);
    prot_mode = v.prot; long_mode = v.lng; cpl = v.cpl; sel_in = v.sel; gdt_limit = v.glim;
    cur_lo = v.lo; cur_hi = v.hi; exp_addr0 = GBASE + {48'd0, v.sel[15:3], 3'b000};
    reads = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 50) begin @(negedge clk); n++; end
    chk(13, "done seen", {63'd0, done}, 64'd1);
    chk(v.rq, "exc_code", {62'd0, exc_code}, {62'd0, v.exc});
    chk(v.rq, "err_sel", {48'd0, err_sel}, {48'd0, v.err});
    chk(7, "read count", reads, {62'd0, v.nrd});
    if (v.exc == 2'd0) begin
      m_sel = v.sel; m_valid = v.ld;
      if (v.ld) begin m_base = v.base; m_lim = v.lim; end
    end
    chk(13, "ldt_sel", {48'd0, ldt_sel}, {48'd0, m_sel});
    chk(13, "ldt_valid", {63'd0, ldt_valid}, {63'd0, m_valid});
    chk(13, "ldt_base", ldt_base, m_base);
    chk(13, "ldt_limit", {32'd0, ldt_limit}, {32'd0, m_lim});
    @(negedge clk);
    chk(13, "done one cycle", {63'd0, done}, 64'd0);
    chk(13, "exc held", {62'd0, exc_code}, {62'd0, v.exc});
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual expired expected finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; prot_mode = 1'b0; long_mode = 1'b0; cpl = 2'd0;
    sel_in = '0; gdt_base = GBASE; gdt_limit = '0; rd_valid = 1'b0; rd_data = '0;
    cur_lo = '0; cur_hi = '0; exp_addr0 = '0;
    m_sel = '0; m_base = '0; m_lim = '0; m_valid = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(1, "ldt_valid", {63'd0, ldt_valid}, 64'd0);
    chk(1, "ldt_sel", {48'd0, ldt_sel}, 64'd0);
    chk(1, "ldt_base", ldt_base, 64'd0);
    chk(1, "ldt_limit", {32'd0, ldt_limit}, 64'd0);
    chk(1, "busy/done/rd_req", {61'd0, busy, done, rd_req}, 64'd0);
    chk(1, "exc/err", {46'd0, exc_code, err_sel}, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(VT[i]);

    // R13 start ignored while busy: second pulse during the read phase
    @(negedge clk);
    prot_mode = 1'b1; long_mode = 1'b0; cpl = 2'd0; sel_in = 16'h0030; gdt_limit = 16'hFFFF;
    cur_lo = 64'h5600_8278_9ABC_0123; exp_addr0 = GBASE + 64'h30; reads = 0; start = 1'b1;
    @(negedge clk);
    prot_mode = 1'b0; sel_in = 16'h0040;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk(13, "busy start exc", {62'd0, exc_code}, 64'd0);
    chk(13, "busy start sel", {48'd0, ldt_sel}, 64'h30);
    chk(11, "busy start base", ldt_base, 64'h0000_0000_5678_9ABC);
    @(negedge clk);
    chk(13, "no second done", {63'd0, done}, 64'd0);
    chk(13, "single read", reads, 64'd1);

    // R1 reset clears a loaded register
    chk(1, "valid before reset", {63'd0, ldt_valid}, 64'd1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk(1, "valid after reset", {63'd0, ldt_valid}, 64'd0);
    chk(1, "base after reset", ldt_base, 64'd0);
    summary();
  end
endmodule